// File: doc/BRIEF.md
# Two-wire bus recovery sequencer

This block sits on the master side of a two-wire serial bus and frees the bus after a transfer was cut off by a reset, a brown-out or a protocol fault. A slave left in the middle of a byte may still be holding the data line low. The sequencer never drives the data line while it clocks. It pulses the clock line until it sees the data line high during a clock-high phase. It then generates a start condition and a stop condition, which resynchronises every slave and leaves the bus idle.

Both lines are driven only through pull-low enables, as open-drain pads would be. Every phase of the sequence is timed by a divider value taken from a runtime input, so one instance can serve any bus speed grade. The divider value is captured when a request is accepted. A requester pulses `req` and waits for `busy` to fall. In the cycle where `busy` falls, a one-cycle `done` pulse means the bus was freed. A one-cycle `fail` pulse means the data line was still low after the ninth clock pulse.

States: IDLE (both lines released) goes to CLK_LOW on a request. CLK_LOW (clock pulled low) goes to CLK_HIGH when its timer expires. CLK_HIGH (clock released) ends when its timer expires. It then goes to START if the data line is high, to FAIL if this was the last allowed pulse, or back to CLK_LOW otherwise. START (data low, clock released) goes to STOP_LOW, STOP_LOW (both low) goes to STOP_HIGH, STOP_HIGH (clock released, data low) goes to STOP_REL, and STOP_REL (both released) goes to DONE, each when its timer expires. DONE and FAIL each last one cycle and return to IDLE.

Top module: `busfree_seq`

## Requirements
- R1: After reset, and while no sequence is running, `scl_oe`, `sda_oe`, `busy`, `done` and `fail` are all 0. An enable at 1 pulls its line low, and an enable at 0 releases it.
- R2: Every timed phase lasts exactly D+1 clock cycles, where D is the divider value captured at the request. The timed phases are the clock-low phase (`scl_oe`=1), the clock-high phase (`scl_oe`=0) and the four start and stop phases. The first clock-low phase begins in the cycle after `req` is sampled high in IDLE.
- R3: `sda_oe` stays 0 throughout every clock-low and clock-high phase of the clocking part.
- R4: The data line is sampled in the last cycle of each clock-high phase. If it reads 1, clocking ends and a start follows: `sda_oe`=1 with `scl_oe`=0 for D+1 cycles. The data line therefore falls while the clock is high.
- R5: After the start comes the stop, in three steps of D+1 cycles each: (`scl_oe`=1, `sda_oe`=1), then (`scl_oe`=0, `sda_oe`=1), then both released. The data line therefore rises while the clock is high.
- R6: In the cycle after the last stop step, `done` is 1 for exactly one cycle with both lines released. The block then returns to IDLE.
- R7: At most 9 clock pulses are issued. If the data line reads 0 at the end of the ninth clock-high phase, `fail` is 1 for one cycle with both lines released, no start is generated, and the block returns to IDLE.
- R8: `req` has no effect while `busy` is 1. A change of `div` during a sequence does not alter that sequence's phase lengths.
- R9: `busy` is 1 from the first clock-low cycle up to and including the `done` or `fail` cycle, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a recovery sequence; sampled in IDLE only |
| div | input | DIV_W | Phase length minus one, in system-clock cycles |
| sda_in | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: bus freed |
| fail | output | 1 | One-cycle pulse: data line still held after the last pulse |

## Verification
Two events can fall in the same cycle: the data-line sample at the end of a clock-high phase, and the decision on whether the pulse limit is reached. The slave model releases the data line exactly in the ninth high phase, and in a second run one phase later. The first run must end in a start and a `done` pulse, and the second in a `fail` pulse with no start. A new request and a divider change are also applied in the same cycles as phase changes inside a running sequence. The per-cycle reference must show no disturbance from either.

// File: rtl/bf_pkg.sv
package bf_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_START,
        ST_STOP_LOW,
        ST_STOP_HIGH,
        ST_STOP_REL,
        ST_DONE,
        ST_FAIL
    } bf_state_t;
endpackage

// File: rtl/bf_phase_timer.sv
module bf_phase_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (cnt != limit)
            cnt <= cnt + 1'b1;
    end

    assign expire = (cnt == limit);

    // R2: a restarted phase begins counting from zero
    a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/bf_pulse_cnt.sv
module bf_pulse_cnt #(
    parameter int MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_PULSES + 1);
    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end

    assign last = (count == CW'(MAX_PULSES - 1));

    // R7: completed pulses never reach the limit
    a_r7_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(MAX_PULSES - 1));
endmodule

// File: rtl/bf_ctrl.sv
module bf_ctrl
    import bf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic sda_in,
    input  logic expire,
    input  logic last_pulse,
    output logic restart,
    output logic pulse_clr,
    output logic pulse_inc,
    output logic accept,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic done,
    output logic fail
);
    bf_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        restart   = 1'b0;
        pulse_inc = 1'b0;
        unique case (state)
            ST_IDLE: if (req) begin
                state_nx = ST_CLK_LOW;
                restart  = 1'b1;
            end
            ST_CLK_LOW: if (expire) begin
                state_nx = ST_CLK_HIGH;
                restart  = 1'b1;
            end
            ST_CLK_HIGH: if (expire) begin
                restart = 1'b1;
                if (sda_in)
                    state_nx = ST_START;
                else if (last_pulse)
                    state_nx = ST_FAIL;
                else begin
                    state_nx  = ST_CLK_LOW;
                    pulse_inc = 1'b1;
                end
            end
            ST_START: if (expire) begin
                state_nx = ST_STOP_LOW;
                restart  = 1'b1;
            end
            ST_STOP_LOW: if (expire) begin
                state_nx = ST_STOP_HIGH;
                restart  = 1'b1;
            end
            ST_STOP_HIGH: if (expire) begin
                state_nx = ST_STOP_REL;
                restart  = 1'b1;
            end
            ST_STOP_REL: if (expire) begin
                state_nx = ST_DONE;
                restart  = 1'b1;
            end
            ST_DONE: state_nx = ST_IDLE;
            ST_FAIL: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    assign accept    = (state == ST_IDLE) && req;
    assign pulse_clr = accept;

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        fail   = 1'b0;
        unique case (state)
            ST_IDLE:      busy = 1'b0;
            ST_CLK_LOW:   scl_oe = 1'b1;
            ST_CLK_HIGH:  ;
            ST_START:     sda_oe = 1'b1;
            ST_STOP_LOW:  begin scl_oe = 1'b1; sda_oe = 1'b1; end
            ST_STOP_HIGH: sda_oe = 1'b1;
            ST_STOP_REL:  ;
            ST_DONE:      done = 1'b1;
            ST_FAIL:      fail = 1'b1;
            default:      busy = 1'b0;
        endcase
    end

    // R6: completion pulses last one cycle and are followed by idle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |=> !busy);
    // R6 / R7: never both outcomes at once
    a_r7_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fail}));
endmodule

// File: rtl/busfree_seq.sv
module busfree_seq #(
    parameter int DIV_W      = 10,
    parameter int MAX_PULSES = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [DIV_W-1:0] div,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             busy,
    output logic             done,
    output logic             fail
);
    logic [DIV_W-1:0] div_q;
    logic restart, pulse_clr, pulse_inc, accept, expire, last_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (accept)
            div_q <= div;
    end

    bf_phase_timer #(.W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .limit(div_q), .expire(expire)
    );

    bf_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_pulses (
        .clk(clk), .rst_n(rst_n), .clear(pulse_clr),
        .inc(pulse_inc), .last(last_pulse)
    );

    bf_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .sda_in(sda_in),
        .expire(expire), .last_pulse(last_pulse), .restart(restart),
        .pulse_clr(pulse_clr), .pulse_inc(pulse_inc), .accept(accept),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
        .done(done), .fail(fail)
    );

    // R4: the data line is pulled low only while the clock is released
    a_r4_start_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_oe);
    // R5: the data line is released only while the clock is released
    a_r5_stop_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_oe);
    // R8: the captured divider holds for the whole sequence
    a_r8_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(div_q));
endmodule

// File: tb/busfree_seq_bench.sv
module busfree_seq_bench;
    localparam int DIV_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic sda_in;
    logic scl_oe, sda_oe, busy, done, fail;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int falls = 0;
    int slave_k = 0;
    logic prev_scl = 1'b1;
    string force_tag = "";

    logic [4:0] eq[$];
    string tq[$];

    always #5 clk = ~clk;

    // slave model: holds the data line low during high phases numbered below slave_k
    assign sda_in = !sda_oe && !(falls < slave_k);

    busfree_seq #(.DIV_W(DIV_W)) u_busfree_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .div(div), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .fail(fail)
    );

    task automatic push(input logic [4:0] v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            eq.push_back(v);
            tq.push_back(force_tag != "" ? force_tag : tag);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // one clock: check at the falling edge against the reference
    task automatic cyc();
        logic [4:0] exp_v;
        logic [4:0] act_v;
        string tag;
        @(negedge clk);
        cycles++;
        if (eq.size() > 0) begin
            exp_v = eq.pop_front();
            tag = tq.pop_front();
        end else begin
            exp_v = 5'b00000;
            tag = "R1";
        end
        act_v = {scl_oe, sda_oe, busy, done, fail};
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s cycle %0d {scl_oe,sda_oe,busy,done,fail} actual=%b expected=%b",
                     tag, cycles, act_v, exp_v);
        end
        if (prev_scl && scl_oe) falls++;
        prev_scl = !scl_oe;
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            summary();
        end
    endtask

    // reference sequence built from the requirements
    task automatic launch(input int k, input int d);
        int np;
        slave_k = k;
        falls = 0;
        div = DIV_W'(d);
        req = 1'b1;
        np = (k > 9) ? 9 : ((k < 1) ? 1 : k);
        for (int p = 0; p < np; p++) begin
            push(5'b10100, d + 1, "R2");   // clock low
            push(5'b00100, d + 1, "R3");   // clock high, data released
        end
        if (k <= 9) begin
            push(5'b01100, d + 1, "R4");
            push(5'b11100, d + 1, "R5");
            push(5'b01100, d + 1, "R5");
            push(5'b00100, d + 1, "R5");
            push(5'b00110, 1, "R6");
        end else begin
            push(5'b00101, 1, "R7");
        end
        cyc();
        req = 1'b0;
    endtask

    task automatic drain();
        while (eq.size() > 0) cyc();
        repeat (3) cyc();
    endtask

    initial begin
        repeat (3) cyc();          // R1: reset values
        rst_n = 1'b1;
        repeat (4) cyc();          // R1: idle after reset

        force_tag = "R9";          // R9: busy window, free bus, shortest phases
        launch(0, 0);
        force_tag = "";
        drain();

        launch(3, 2);              // R2 R4 R5: released after three pulses
        drain();

        launch(9, 1);              // R7: release in the ninth high phase still succeeds
        drain();

        launch(10, 1);             // R7: still held after ninth pulse
        drain();

        launch(20, 0);             // R7: fail with single-cycle phases
        drain();

        force_tag = "R8";          // R8: request and divider change mid-sequence
        launch(5, 3);
        repeat (6) cyc();
        req = 1'b1;
        div = 10'd7;
        cyc();
        req = 1'b0;
        repeat (9) cyc();
        req = 1'b1;
        cyc();
        req = 1'b0;
        drain();
        force_tag = "";

        launch(2, 4);              // R8: new divider taken at the next request
        drain();

        summary();
    end
endmodule